// File: doc/BRIEF.md
# SPI Slave-Select Manager

This block owns the slave-select line of an SPI controller that can run as bus master or as a selected target. Configuration bits from a register bank choose one of three select-line policies. Under firmware control the internal select level is a register bit and the pin is left free. Under driven control the master pulls the pin low while it is enabled. Under sensed control the pin is an input: a target reads it as its chip select, and a master watches it for a competing master. The shift engine sends frame-start and frame-end strobes and a flag saying another word is queued. With those the block can raise the line for one SPI clock period between back-to-back words.

A master in sensed mode that sees the line go low records a sticky mode fault. While the fault is set, the enable and master bits reaching the rest of the controller are forced to zero, and the controller drops back to target operation. The pin level and the pin's driver enable are both registered, so no combinational spike reaches the pad. The incoming pin passes through a synchronizer before any decision uses it.

Top module: `ss_manager`

## Requirements
- R1: After reset `nss_o` is 1, `nss_oe_o` is 0 and `mode_fault_o` is 0.
- R2: With `sw_mgmt_i`=1 (firmware policy), `ss_int_o` equals `sw_sel_i` in the same cycle and `nss_oe_o` is 0.
- R3: With `sw_mgmt_i`=0, `out_en_i`=1 and `master_i`=1 (driven policy), `nss_oe_o` is 1 one cycle later. `nss_o` is 0 one cycle after `en_i` becomes 1 and 1 one cycle after `en_i` becomes 0.
- R4: In the driven policy with `pulse_en_i`=1, `frame_end_i`=1 together with `next_pending_i`=1 after a `frame_start_i` since the last frame end raises `nss_o` from the next cycle for exactly SCK_DIV cycles, after which it returns to 0.
- R5: No pulse is produced when `next_pending_i`=0 or `pulse_en_i`=0; `nss_o` stays 0.
- R6: A frame end with no frame start since the previous frame end produces no pulse.
- R7: With `sw_mgmt_i`=0, `out_en_i`=0 (sensed policy), `master_i`=1 and `en_i`=1, a low on `nss_in_i` sets `mode_fault_o` three cycles later, two synchronizer stages plus one register. From that cycle on `force_slave_o`=1 and `eff_master_o`=`eff_en_o`=0.
- R8: The mode fault stays set until `fault_clr_i`=1. A clear that arrives while the synchronized pin is still low is overridden. A clear with the pin high drops the fault one cycle later.
- R9: In the sensed policy, `ss_int_o` follows `nss_in_i` two cycles late, and `nss_oe_o` is 0. A target (`master_i`=0) never raises a fault.
- R10: In the driven policy with `master_i`=0, `nss_oe_o` is 0 and `nss_o` is 1.
- R11: Switching into the driven policy while already enabled as master makes `nss_o` fall one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Peripheral enable bit |
| master_i | input | 1 | Master select bit |
| sw_mgmt_i | input | 1 | 1 = firmware controls the internal select |
| sw_sel_i | input | 1 | Internal select level used under firmware policy |
| out_en_i | input | 1 | 1 = pin driven by master, 0 = pin sensed |
| pulse_en_i | input | 1 | Enables the inter-word high pulse |
| fault_clr_i | input | 1 | Register write clearing the mode fault |
| frame_start_i | input | 1 | Shift engine began a word |
| frame_end_i | input | 1 | Shift engine finished a word |
| next_pending_i | input | 1 | Another word follows back to back |
| nss_in_i | input | 1 | Select pin input (asynchronous) |
| nss_o | output | 1 | Select pin output level |
| nss_oe_o | output | 1 | Select pin driver enable |
| ss_int_o | output | 1 | Internal select level (active low) |
| mode_fault_o | output | 1 | Sticky mode-fault flag |
| force_slave_o | output | 1 | Master request overridden by fault |
| eff_master_o | output | 1 | Master bit after fault gating |
| eff_en_o | output | 1 | Enable bit after fault gating |

## Verification
The assertions assume that the configuration bits change only between bench steps, so each `$past` of them describes a settled register. They also assume that the shift engine never sends a frame start while an inter-word pulse is still running. The stimulus changes inputs only on the falling edge and holds each strobe for one cycle. It issues a new frame start only after the pulse window the bench has already predicted has ended.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        SEL_FIRMWARE = 2'd0,
        SEL_DRIVEN   = 2'd1,
        SEL_SENSED   = 2'd2
    } sel_policy_e;

    typedef struct packed {
        logic en;
        logic master;
        logic sw_mgmt;
        logic sw_sel;
        logic out_en;
        logic pulse_en;
    } sel_cfg_t;

    function automatic sel_policy_e decode_policy(input sel_cfg_t cfg);
        if (cfg.sw_mgmt)     return SEL_FIRMWARE;
        else if (cfg.out_en) return SEL_DRIVEN;
        else                 return SEL_SENSED;
    endfunction

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '1;
                else       chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '1;
                else       chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ss_fault.sv
module ss_fault (
    input  logic clk_i,
    input  logic rst_i,
    input  logic watch_i,
    input  logic pin_sync_i,
    input  logic clr_i,
    output logic fault_o
);
    logic fault_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                       fault_q <= 1'b0;
        else if (watch_i && !pin_sync_i) fault_q <= 1'b1;
        else if (clr_i)                  fault_q <= 1'b0;
    end

    assign fault_o = fault_q;

    // R8: only a clear request can drop the flag
    assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(fault_q) && !$past(clr_i) |-> fault_q);
endmodule

// File: rtl/ss_out_gen.sv
module ss_out_gen #(
    parameter int SCK_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic active_i,
    input  logic oe_req_i,
    input  logic pulse_en_i,
    input  logic frame_start_i,
    input  logic frame_end_i,
    input  logic next_pending_i,
    output logic nss_o,
    output logic oe_o
);
    localparam int CW = $clog2(SCK_DIV + 1);
    localparam logic [CW-1:0] PULSE_LEN = CW'(SCK_DIV);

    logic          armed_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          nss_q, oe_q;
    logic          start;

    assign start = active_i && pulse_en_i && frame_end_i && next_pending_i && armed_q;

    always_comb begin
        if (!active_i)        cnt_d = '0;
        else if (start)       cnt_d = PULSE_LEN;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else                  cnt_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            nss_q   <= 1'b1;
            oe_q    <= 1'b0;
        end else begin
            if (!active_i)          armed_q <= 1'b0;
            else if (frame_start_i) armed_q <= 1'b1;
            else if (frame_end_i)   armed_q <= 1'b0;
            cnt_q <= cnt_d;
            nss_q <= !active_i || (cnt_d != '0);
            oe_q  <= oe_req_i;
        end
    end

    assign nss_o = nss_q;
    assign oe_o  = oe_q;

    // R4, R5: a rise while continuously active must come from a queued word end
    assert_pulse_cause_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(nss_q) && $past(active_i, 2) && $past(active_i)
        |-> $past(frame_end_i && next_pending_i && pulse_en_i));
endmodule

// File: rtl/ss_manager.sv
module ss_manager
    import ss_pkg::*;
#(
    parameter int SCK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic master_i,
    input  logic sw_mgmt_i,
    input  logic sw_sel_i,
    input  logic out_en_i,
    input  logic pulse_en_i,
    input  logic fault_clr_i,
    input  logic frame_start_i,
    input  logic frame_end_i,
    input  logic next_pending_i,
    input  logic nss_in_i,
    output logic nss_o,
    output logic nss_oe_o,
    output logic ss_int_o,
    output logic mode_fault_o,
    output logic force_slave_o,
    output logic eff_master_o,
    output logic eff_en_o
);
    sel_cfg_t    cfg;
    sel_policy_e policy;
    logic        pin_sync, fault, eff_master, eff_en, drive_active, drive_req, watch;

    assign cfg = '{en: en_i, master: master_i, sw_mgmt: sw_mgmt_i,
                   sw_sel: sw_sel_i, out_en: out_en_i, pulse_en: pulse_en_i};
    assign policy = decode_policy(cfg);

    assign eff_en       = cfg.en && !fault;
    assign eff_master   = cfg.master && !fault;
    assign drive_req    = (policy == SEL_DRIVEN) && eff_master;
    assign drive_active = drive_req && eff_en;
    assign watch        = (policy == SEL_SENSED) && cfg.en && cfg.master;

    ss_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(nss_in_i), .q_o(pin_sync)
    );

    ss_fault i_fault (
        .clk_i(clk_i), .rst_i(rst_i), .watch_i(watch),
        .pin_sync_i(pin_sync), .clr_i(fault_clr_i), .fault_o(fault)
    );

    ss_out_gen #(.SCK_DIV(SCK_DIV)) i_out (
        .clk_i(clk_i), .rst_i(rst_i), .active_i(drive_active), .oe_req_i(drive_req),
        .pulse_en_i(cfg.pulse_en), .frame_start_i(frame_start_i),
        .frame_end_i(frame_end_i), .next_pending_i(next_pending_i),
        .nss_o(nss_o), .oe_o(nss_oe_o)
    );

    always_comb begin
        unique case (policy)
            SEL_FIRMWARE: ss_int_o = cfg.sw_sel;
            SEL_DRIVEN:   ss_int_o = eff_master ? 1'b1 : pin_sync;
            default:      ss_int_o = pin_sync;
        endcase
    end

    assign mode_fault_o  = fault;
    assign force_slave_o = fault && cfg.master;
    assign eff_master_o  = eff_master;
    assign eff_en_o      = eff_en;

    // R10: the pad driver only turns on after a driven-policy master request
    assert_oe_policy_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        nss_oe_o |-> $past(!sw_mgmt_i && out_en_i && master_i));
    // R3: a disabled peripheral leaves the line high
    assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!en_i) |-> nss_o);
    // R7: a fault only arises for a sensed-policy master
    assert_fault_origin_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(mode_fault_o) |-> $past(master_i && !sw_mgmt_i && !out_en_i && en_i));
    // R7: a fault held over two cycles keeps the pad released
    assert_fault_releases_pad_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_fault_o && $past(mode_fault_o) |-> !nss_oe_o);
endmodule

// File: tb/test_ss_manager.sv
module test_ss_manager;
    localparam int SCK_DIV = 4;

    typedef struct {
        int    due;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic en = 0, master = 0, sw_mgmt = 0, sw_sel = 0, out_en = 0, pulse_en = 0;
    logic fault_clr = 0, f_start = 0, f_end = 0, pending = 0, nss_in = 1;
    logic nss, oe, ss_int, fault, force_s, eff_m, eff_e;

    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ss_manager #(.SCK_DIV(SCK_DIV), .SYNC_STAGES(2)) i_ss_manager (
        .clk_i(clk), .rst_i(rst), .en_i(en), .master_i(master), .sw_mgmt_i(sw_mgmt),
        .sw_sel_i(sw_sel), .out_en_i(out_en), .pulse_en_i(pulse_en),
        .fault_clr_i(fault_clr), .frame_start_i(f_start), .frame_end_i(f_end),
        .next_pending_i(pending), .nss_in_i(nss_in), .nss_o(nss), .nss_oe_o(oe),
        .ss_int_o(ss_int), .mode_fault_o(fault), .force_slave_o(force_s),
        .eff_master_o(eff_m), .eff_en_o(eff_e)
    );

    localparam int S_NSS = 0, S_OE = 1, S_INT = 2, S_FLT = 3, S_FRC = 4, S_EM = 5, S_EE = 6;

    function automatic logic pick(int s);
        case (s)
            S_NSS:   return nss;
            S_OE:    return oe;
            S_INT:   return ss_int;
            S_FLT:   return fault;
            S_FRC:   return force_s;
            S_EM:    return eff_m;
            default: return eff_e;
        endcase
    endfunction

    task automatic expect_in(int k, int s, logic v, string tag);
        sb.push_back('{due: cyc + k, sig: s, val: v, tag: tag});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops due items and compares with the outputs
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                checks++;
                if (pick(sb[i].sig) !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s sig%0d actual %b expected %b at cycle %0d",
                             sb[i].tag, sb[i].sig, pick(sb[i].sig), sb[i].val, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic strobe_start();
        f_start = 1; step(1); f_start = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        expect_in(1, S_NSS, 1, "R1"); expect_in(1, S_OE, 0, "R1"); expect_in(1, S_FLT, 0, "R1");
        step(2);

        // R2 firmware policy
        sw_mgmt = 1; sw_sel = 0; en = 1; master = 1; out_en = 1;
        expect_in(1, S_INT, 0, "R2"); expect_in(2, S_OE, 0, "R2"); expect_in(2, S_NSS, 1, "R2");
        step(2);
        sw_sel = 1; expect_in(1, S_INT, 1, "R2");
        step(2);

        // R11 switch into driven policy while enabled
        sw_mgmt = 0;
        expect_in(1, S_NSS, 0, "R11"); expect_in(1, S_OE, 1, "R3");
        step(3);
        en = 0; expect_in(1, S_NSS, 1, "R3"); expect_in(1, S_OE, 1, "R3");
        step(2);
        en = 1; expect_in(1, S_NSS, 0, "R3");
        step(2);

        // R4 inter-word pulse
        pulse_en = 1;
        strobe_start(); step(2);
        f_end = 1; pending = 1;
        for (int k = 1; k <= SCK_DIV; k++) expect_in(k, S_NSS, 1, "R4");
        expect_in(SCK_DIV + 1, S_NSS, 0, "R4");
        step(1); f_end = 0; pending = 0;
        step(SCK_DIV + 2);

        // R5 no pending word
        strobe_start(); step(1);
        f_end = 1; pending = 0;
        expect_in(1, S_NSS, 0, "R5"); expect_in(2, S_NSS, 0, "R5");
        step(1); f_end = 0; step(2);

        // R6 frame end without a frame start
        f_end = 1; pending = 1;
        expect_in(1, S_NSS, 0, "R6"); expect_in(2, S_NSS, 0, "R6");
        step(1); f_end = 0; pending = 0; step(2);

        // R5 pulse mode off
        pulse_en = 0; strobe_start(); step(1);
        f_end = 1; pending = 1;
        expect_in(1, S_NSS, 0, "R5"); expect_in(2, S_NSS, 0, "R5");
        step(1); f_end = 0; pending = 0; step(2);

        // R10 driven policy as target
        master = 0;
        expect_in(1, S_OE, 0, "R10"); expect_in(1, S_NSS, 1, "R10");
        step(2);

        // R9 sensed policy as target
        out_en = 0; nss_in = 0;
        expect_in(1, S_INT, 1, "R9"); expect_in(2, S_INT, 0, "R9");
        expect_in(1, S_OE, 0, "R9"); expect_in(3, S_FLT, 0, "R9");
        step(4);
        nss_in = 1; step(4);

        // R7 sensed-policy master sees the line low
        master = 1; step(1);
        nss_in = 0;
        expect_in(2, S_FLT, 0, "R7"); expect_in(3, S_FLT, 1, "R7");
        expect_in(3, S_FRC, 1, "R7"); expect_in(3, S_EM, 0, "R7"); expect_in(3, S_EE, 0, "R7");
        step(4);

        // R8 clear overridden while the line is low, then sticky, then cleared
        fault_clr = 1; expect_in(1, S_FLT, 1, "R8");
        step(1); fault_clr = 0; nss_in = 1;
        step(3);
        expect_in(1, S_FLT, 1, "R8");
        step(1);
        fault_clr = 1;
        expect_in(1, S_FLT, 0, "R8"); expect_in(1, S_EM, 1, "R8");
        step(1); fault_clr = 0;
        step(3);

        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule